// File: doc/BRIEF.md
# Serial Console Register Block

This block is the register side of a simple serial console, attached as an APB slave. It decodes four full-word registers in a 256-byte window: data, status, control and a scaler. Received bytes come in on a one-cycle valid strobe and are queued in an 8-entry receive FIFO. A read of the data register takes the oldest byte from that FIFO. A write to the data register sends its low byte out on a transmit strobe. There is no transmit queue and no line timing.

Software sees the state of the FIFO and a set of sticky error flags in the status register. The error flags stay set until software writes zero to them. A single level interrupt output combines two sources. The first is receive data waiting while receive interrupts are enabled. The second is a transmit event that is still pending. Serialization, baud generation, parity checking, flow control and loopback lie outside this block. The scaler is plain storage.

Top module: `serial_console_regs`

## Requirements
- R1: Word offsets are 0x00 data, 0x04 status, 0x08 control and 0x0C scaler. Control keeps bits 11:0 as written and reads bit 31 as 1, with every other bit 0. The scaler reads back all 32 bits. Reads of any other offset in the window return 0, and writes to them have no effect.
- R2: An access with paddr[1:0] not equal to 0, or a write with pstrb not equal to 4'hF, completes with pslverr=1 and changes no state. It does not pop the FIFO and does not transmit.
- R3: After reset, control reads 0x80000000, the scaler reads 0, status reads 0x80000006 and the FIFO is empty. Both irq and tx_valid are 0.
- R4: Each rx_valid pulse pushes rx_data into the FIFO. Data-register reads return the bytes in arrival order in bits 7:0. Status bit 0 is 1 while the FIFO holds data, and status bit 27 is 1 when it holds 8 bytes.
- R5: A data-register read while the FIFO is empty returns 0 and changes nothing.
- R6: A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped. It sets overrun (status bit 4) and errored (status bit 7).
- R7: Status bits 4 to 7 are sticky. A full-word status write clears each of these bits whose written value is 0 and keeps each one written as 1. A flag raised in the same cycle as a clearing write stays set.
- R8: rx_perr and rx_ferr, when sampled together with rx_valid, set parity error (bit 5) and framing error (bit 6) respectively. Each also sets errored (bit 7).
- R9: A data write with control bit 1 (transmit enable) set drives tx_valid high for exactly the next cycle, with tx_data equal to pwdata[7:0]. With bit 1 clear, the write is dropped with no effect.
- R10: irq is 1 whenever control bits 0 (receive enable) and 2 (receive interrupt enable) are both set and the FIFO is not empty. It changes in the cycle after the state that causes it.
- R11: A transmitted byte sets a transmit-interrupt pending flag when control bit 3 is 1. That flag drives irq. It clears on the next status read, or on the next transmitted byte while bit 3 is 0.
- R12: A push and a data-register pop in the same cycle both take effect. The byte count stays the same, and this holds even when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB write byte strobes |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error response for partial or unaligned access |
| rx_valid | input | 1 | One-cycle strobe, received byte present |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag for the received byte |
| rx_ferr | input | 1 | Framing error flag for the received byte |
| tx_valid | output | 1 | One-cycle strobe, byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can fall in the same cycle. A byte can arrive from the line while software pops the FIFO through a data read. An error flag can be raised while software writes zero to the status register. The bench provokes both by driving rx_valid during the access phase of the APB read or write. It does this once with the FIFO full and once with it partly filled. A behavioural queue model computes the outcome, and the bench then compares the model with every read value, the full and overrun bits, and the irq level on each clock.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;
  localparam int BUS_W  = 32;
  localparam int CTRL_W = 12;

  // control bit positions
  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_RXIE = 2;
  localparam int C_TXIE = 3;
  localparam int C_FIXED = 31;

  // status bit positions
  localparam int S_DR = 0;
  localparam int S_TS = 1;
  localparam int S_TE = 2;
  localparam int S_BR = 3;
  localparam int S_OV = 4;
  localparam int S_PE = 5;
  localparam int S_FE = 6;
  localparam int S_ER = 7;
  localparam int S_TF = 26;
  localparam int S_RF = 27;
  localparam int S_FA = 31;

  // word indices inside the window
  localparam int W_DATA = 0;
  localparam int W_STAT = 1;
  localparam int W_CTRL = 2;
  localparam int W_SCAL = 3;
endpackage

// File: rtl/con_rx_fifo.sv
module con_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign overrun = push && full && !do_pop;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    count_next = count;
    if (do_push && !do_pop) count_next = count + CNT_W'(1);
    else if (do_pop && !do_push) count_next = count - CNT_W'(1);
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count_next;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    overrun |=> count == CNT_W'(DEPTH)); // R6
  AST_SIMUL_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> count == $past(count)); // R12
endmodule

// File: rtl/con_apb_decode.sv
module con_apb_decode
  import con_uart_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [3:0]        pstrb,
  output logic              acc_err,
  output logic [WORD_W-1:0] word,
  output logic              rd_data,
  output logic              wr_data,
  output logic              rd_stat,
  output logic              wr_stat,
  output logic              wr_ctrl,
  output logic              wr_scal
);
  logic acc, bad, ok;

  assign word    = paddr[ADDR_W-1:2];
  assign acc     = psel && penable;
  assign bad     = (paddr[1:0] != 2'b00) || (pwrite && pstrb != 4'hF);
  assign acc_err = acc && bad;
  assign ok      = acc && !bad;

  assign rd_data = ok && !pwrite && word == WORD_W'(W_DATA);
  assign wr_data = ok &&  pwrite && word == WORD_W'(W_DATA);
  assign rd_stat = ok && !pwrite && word == WORD_W'(W_STAT);
  assign wr_stat = ok &&  pwrite && word == WORD_W'(W_STAT);
  assign wr_ctrl = ok &&  pwrite && word == WORD_W'(W_CTRL);
  assign wr_scal = ok &&  pwrite && word == WORD_W'(W_SCAL);
endmodule

// File: rtl/con_tx_irq.sv
module con_tx_irq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tx_en,
  input  logic              tx_ie,
  input  logic              stat_rd,
  input  logic              rx_cond_next,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic send, pend_q, pend_next;

  assign send = data_wr && tx_en;

  always_comb begin
    pend_next = pend_q;
    if (send && tx_ie) pend_next = 1'b1;
    else if (stat_rd || send) pend_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      pend_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tx_valid <= send;
      if (send) tx_data <= wbyte;
      pend_q <= pend_next;
      irq    <= rx_cond_next || pend_next;
    end
  end

  AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !tx_en) |=> !tx_valid); // R9
  AST_PEND_DRIVES_IRQ: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> irq); // R11
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !send) |=> !pend_q); // R11
endmodule

// File: rtl/serial_console_regs.sv
module serial_console_regs
  import con_uart_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int FIFO_D   = 8,
  parameter int SCALER_W = 32,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int CNT_W   = $clog2(FIFO_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  input  logic [3:0]        pstrb,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic              acc_err;
  logic [WORD_W-1:0] word;
  logic rd_data, wr_data, rd_stat, wr_stat, wr_ctrl, wr_scal;

  con_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pstrb(pstrb), .acc_err(acc_err), .word(word), .rd_data(rd_data),
    .wr_data(wr_data), .rd_stat(rd_stat), .wr_stat(wr_stat),
    .wr_ctrl(wr_ctrl), .wr_scal(wr_scal)
  );

  logic [7:0]       f_rdata;
  logic             f_empty, f_full, f_ovr;
  logic [CNT_W-1:0] f_cnt, f_cnt_next;

  con_rx_fifo #(.DEPTH(FIFO_D), .DATA_W(8)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_valid), .wdata(rx_data), .pop(rd_data),
    .rdata(f_rdata), .empty(f_empty), .full(f_full), .overrun(f_ovr),
    .count(f_cnt), .count_next(f_cnt_next)
  );

  logic [CTRL_W-1:0]   ctrl_q, ctrl_next;
  logic [SCALER_W-1:0] scal_q;
  logic ov_q, pe_q, fe_q, er_q;
  logic set_pe, set_fe, set_er;

  assign ctrl_next = wr_ctrl ? pwdata[CTRL_W-1:0] : ctrl_q;
  assign set_pe    = rx_valid && rx_perr;
  assign set_fe    = rx_valid && rx_ferr;
  assign set_er    = f_ovr || set_pe || set_fe;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      scal_q <= '0;
      ov_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_next;
      if (wr_scal) scal_q <= pwdata[SCALER_W-1:0];
      ov_q <= ((wr_stat ? pwdata[S_OV] : 1'b1) && ov_q) || f_ovr;
      pe_q <= ((wr_stat ? pwdata[S_PE] : 1'b1) && pe_q) || set_pe;
      fe_q <= ((wr_stat ? pwdata[S_FE] : 1'b1) && fe_q) || set_fe;
      er_q <= ((wr_stat ? pwdata[S_ER] : 1'b1) && er_q) || set_er;
    end
  end

  logic rx_cond_next;
  assign rx_cond_next = ctrl_next[C_RXEN] && ctrl_next[C_RXIE] && (f_cnt_next != '0);

  con_tx_irq #(.BYTE_W(8)) u_txi (
    .clk(clk), .rst(rst), .data_wr(wr_data), .wbyte(pwdata[7:0]),
    .tx_en(ctrl_q[C_TXEN]), .tx_ie(ctrl_q[C_TXIE]), .stat_rd(rd_stat),
    .rx_cond_next(rx_cond_next), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq(irq)
  );

  logic [BUS_W-1:0] status, ctrl_rd, scal_rd, rd_mux;

  always_comb begin
    status       = '0;
    status[S_DR] = !f_empty;
    status[S_TS] = 1'b1;
    status[S_TE] = 1'b1;
    status[S_BR] = 1'b0;
    status[S_OV] = ov_q;
    status[S_PE] = pe_q;
    status[S_FE] = fe_q;
    status[S_ER] = er_q;
    status[S_TF] = 1'b0;
    status[S_RF] = f_full;
    status[S_FA] = 1'b1;
    ctrl_rd               = '0;
    ctrl_rd[CTRL_W-1:0]   = ctrl_q;
    ctrl_rd[C_FIXED]      = 1'b1;
    scal_rd               = '0;
    scal_rd[SCALER_W-1:0] = scal_q;
  end

  always_comb begin
    unique case (word)
      WORD_W'(W_DATA): rd_mux = f_empty ? '0 : {{(BUS_W-8){1'b0}}, f_rdata};
      WORD_W'(W_STAT): rd_mux = status;
      WORD_W'(W_CTRL): rd_mux = ctrl_rd;
      WORD_W'(W_SCAL): rd_mux = scal_rd;
      default:         rd_mux = '0;
    endcase
  end

  assign prdata  = acc_err ? '0 : rd_mux;
  assign pready  = 1'b1;
  assign pslverr = acc_err;

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    pslverr |=> ($stable(ctrl_q) && $stable(scal_q) && !tx_valid)); // R2
  AST_ERR_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (pslverr && !rx_valid) |=> $stable(f_cnt)); // R2
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (rst)
    f_ovr |=> (ov_q && er_q)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !wr_stat) |=> ov_q); // R7
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_RXEN] && ctrl_q[C_RXIE] && !f_empty) |-> irq); // R10
endmodule

// File: tb/sim_serial_console_regs.sv
module sim_serial_console_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [3:0]  pstrb;
  logic        pready, pslverr;
  logic        rx_valid, rx_perr, rx_ferr, tx_valid, irq;
  logic [7:0]  rx_data, tx_data;

  serial_console_regs u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference model
  logic [7:0]  q[$];
  logic [11:0] m_ctrl;
  logic [31:0] m_scal;
  bit m_ov, m_pe, m_fe, m_er, m_pend, m_irq, m_txv;
  logic [7:0] m_txd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    case (a[7:2])
      6'd0: v = (q.size() > 0) ? {24'd0, q[0]} : 32'd0;
      6'd1: begin
        v = 32'h8000_0006;
        v[0] = q.size() > 0;
        v[4] = m_ov; v[5] = m_pe; v[6] = m_fe; v[7] = m_er;
        v[27] = q.size() == 8;
      end
      6'd2: v = {20'h80000, m_ctrl};
      6'd3: v = m_scal;
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_ctrl = '0; m_scal = '0;
      m_ov = 0; m_pe = 0; m_fe = 0; m_er = 0;
      m_pend = 0; m_irq = 0; m_txv = 0; m_txd = '0;
    end else begin
      bit acc, bad, ok, pop, full, sov, spe, sfe, send;
      logic [5:0] w;
      acc  = psel && penable;
      bad  = (paddr[1:0] != 0) || (pwrite && pstrb != 4'hF);
      ok   = acc && !bad;
      w    = paddr[7:2];
      pop  = ok && !pwrite && w == 0 && q.size() > 0;
      full = q.size() == 8;
      sov  = rx_valid && full && !pop;
      spe  = rx_valid && rx_perr;
      sfe  = rx_valid && rx_ferr;
      send = ok && pwrite && w == 0 && m_ctrl[1];
      if (ok && pwrite && w == 1) begin
        m_ov &= pwdata[4]; m_pe &= pwdata[5]; m_fe &= pwdata[6]; m_er &= pwdata[7];
      end
      m_ov |= sov; m_pe |= spe; m_fe |= sfe; m_er |= (sov || spe || sfe);
      if (pop) void'(q.pop_front());
      if (rx_valid && !sov) q.push_back(rx_data);
      m_txv = send;
      if (send) m_txd = pwdata[7:0];
      if (send && m_ctrl[3]) m_pend = 1;
      else if ((ok && !pwrite && w == 1) || send) m_pend = 0;
      if (ok && pwrite && w == 2) m_ctrl = pwdata[11:0];
      if (ok && pwrite && w == 3) m_scal = pwdata;
      m_irq = (m_ctrl[0] && m_ctrl[2] && q.size() > 0) || m_pend;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // registered outputs compared every cycle
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10/R11 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 tx_valid", {31'd0, tx_valid}, {31'd0, m_txv});
      if (m_txv) chk("R9 tx_data", {24'd0, tx_data}, {24'd0, m_txd});
    end
  end

  task automatic apb(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, input string tag,
                     input bit rxv = 0, input logic [7:0] rxb = 0,
                     input bit pe = 0, input bit fe = 0);
    bit exp_err;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1;
    rx_valid = rxv; rx_data = rxb; rx_perr = pe; rx_ferr = fe;
    #1;
    exp_err = (a[1:0] != 0) || (wr && s != 4'hF);
    chk({tag, " pslverr"}, {31'd0, pslverr}, {31'd0, exp_err});
    if (!wr && !exp_err) chk({tag, " prdata"}, prdata, m_read(a));
    @(posedge clk); #1;
    psel = 0; penable = 0; rx_valid = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    apb(0, a, 32'd0, 4'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    apb(1, a, d, 4'hF, tag);
  endtask

  task automatic push(input logic [7:0] b, input bit pe = 0, input bit fe = 0);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rx_perr = pe; rx_ferr = fe;
    @(posedge clk); #1;
    rx_valid = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; pstrb = 0;
    rx_valid = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R3 reset values
    rd(8'h04, "R3 status");
    chk("R3 status value", prdata, 32'h8000_0006);
    rd(8'h08, "R3 ctrl");
    rd(8'h0C, "R3 scaler");
    rd(8'h00, "R5 empty data");

    // R1 register readback and unmapped space
    wr(8'h0C, 32'hDEAD_BEEF, "R1 scaler wr");
    rd(8'h0C, "R1 scaler");
    wr(8'h08, 32'hFFFF_F0F0, "R1 ctrl wr");
    rd(8'h08, "R1 ctrl");
    wr(8'h40, 32'h1234_5678, "R1 unmapped wr");
    rd(8'h40, "R1 unmapped");
    rd(8'hFC, "R1 top word");

    // R2 partial and unaligned accesses
    wr(8'h08, 32'h0, "R1 ctrl clear");
    apb(1, 8'h08, 32'h0000_0FFF, 4'h3, "R2 half write");
    rd(8'h08, "R2 ctrl unchanged");
    apb(1, 8'h0C, 32'h0, 4'h1, "R2 byte write");
    rd(8'h0C, "R2 scaler unchanged");

    // R9 transmit
    wr(8'h08, 32'h2, "R9 ctrl te");
    wr(8'h00, 32'h0000_01A5, "R9 send");
    apb(1, 8'h02, 32'h77, 4'hF, "R2 unaligned data write");
    wr(8'h08, 32'h0, "R9 ctrl off");
    wr(8'h00, 32'h3C, "R9 dropped");

    // R11 transmit interrupt
    wr(8'h08, 32'hA, "R11 ctrl te ti");
    wr(8'h00, 32'h11, "R11 send ti");
    repeat (2) @(negedge clk);
    rd(8'h04, "R11 status clears");
    wr(8'h00, 32'h22, "R11 send ti again");
    wr(8'h08, 32'h2, "R11 ti off");
    wr(8'h00, 32'h33, "R11 send clears");

    // R4 R10 receive path
    wr(8'h08, 32'h5, "R10 ctrl re ri");
    push(8'h41); push(8'h42); push(8'h43);
    rd(8'h04, "R4 status dr");
    apb(0, 8'h01, 32'h0, 4'h0, "R2 unaligned data read");
    rd(8'h00, "R4 pop1");
    rd(8'h00, "R4 pop2");
    rd(8'h00, "R4 pop3");
    rd(8'h00, "R5 empty again");
    rd(8'h04, "R5 status after empty");

    // R6 overrun and R7 sticky clear
    for (int i = 0; i < 8; i++) push(8'h50 + 8'(i));
    rd(8'h04, "R4 full status");
    push(8'hEE);
    rd(8'h04, "R6 overrun status");
    wr(8'h04, 32'hFFFF_FFFF, "R7 write ones");
    rd(8'h04, "R7 kept");
    wr(8'h04, 32'h0, "R7 write zero");
    rd(8'h04, "R7 cleared");

    // R12 push and pop together while full
    apb(0, 8'h00, 32'h0, 4'h0, "R12 pop with push full", 1, 8'h99);
    rd(8'h04, "R12 still full no ov");
    for (int i = 0; i < 8; i++) rd(8'h00, "R12 drain order");
    rd(8'h00, "R5 empty after drain");

    // R8 line errors, and R7 set beats clear
    push(8'h61, 1, 0);
    push(8'h62, 0, 1);
    rd(8'h04, "R8 pe fe er");
    apb(1, 8'h04, 32'h0, 4'hF, "R7 clear with set", 1, 8'h63, 1, 0);
    rd(8'h04, "R7 pe survives");
    apb(0, 8'h00, 32'h0, 4'h0, "R12 pop with push partial", 1, 8'h64);
    rd(8'h04, "R12 count");
    wr(8'h08, 32'h0, "R10 disable");
    repeat (2) @(negedge clk);
    rd(8'h00, "R4 pop tail1");
    rd(8'h00, "R4 pop tail2");
    rd(8'h00, "R4 pop tail3");
    rd(8'h00, "R5 final empty");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule